// File: doc/BRIEF.md
# Segmented Contiguous Vector Load Sequencer

This block carries out one contiguous vector load from memory into a vector register file. The load may be segmented: each element then consists of several consecutive fields in memory, and each field goes to its own destination register group. A start pulse latches the load shape: destination base register, element width, group size, field count, masking, truncate-on-fault mode, base address, active length and resume index. The block also snapshots the mask vector at that moment.

The block walks the element index upward from the resume index to the active length and skips each element whose mask bit is clear. For each live element it issues one read per field on a request/response memory port and keeps at most one read in flight. It parks every returned field in a small field buffer. Only when the whole element has arrived does it write the fields, one per cycle, through a byte-addressed register-file write port.

A memory error ends the operation. In truncate-on-fault mode, an error past element 0 shortens the active length. Otherwise the error becomes a trap, and the resume index records how far the load got. A one-cycle done pulse reports the outcome together with the updated length, resume index and a state-modified flag.

Top module: `seg_load_seq`

## Requirements
- R1: The read for field f of element i is at base + i·(nf·eb) + f·eb, modulo 2^ADDR_W, where eb = 1 << eew code (codes 0,1,2,3 mean 1,2,4,8 bytes) and nf is the field count 1..8. Reads are issued for fields 0..nf-1 of an element, and elements are visited in ascending order starting at the resume index.
- R2: When masking is on, element i is live only if mask_bits[i] is 1, which is bit i mod 8 of mask byte i/8. A dead element produces no read and no write. When masking is off, every element is live whatever the mask holds.
- R3: Field f of element i is written to register (dst + f·grp + i / (VLENB/eb)) mod 32, at byte offset (i mod (VLENB/eb))·eb, with rf_eew equal to the element width code.
- R4: No field of an element is written before all nf fields of that element have returned without error. An element whose read faults writes nothing.
- R5: done is a single-cycle pulse. A load that completes without error reports err 0 and dirty 1, resume index 0, and the length unchanged. If the resume index is already at or beyond the length, the load completes in this way without issuing any read.
- R6: In truncate-on-fault mode, a read error at element i > 0 completes with err 0, length i, resume index 0 and dirty 1.
- R7: In every other error case, the block reports err 1 and leaves the length unchanged. If i is greater than the resume index, the resume index becomes i and dirty is 1. Otherwise the resume index is unchanged and dirty is 0.
- R8: A read error at element 0 is always reported as err 1, even in truncate-on-fault mode.
- R9: mem_req is a one-cycle pulse, and no new request is issued until the response to the previous one has arrived.
- R10: rf_wdata carries the returned memory bytes little-endian in its low eb bytes, and every byte above them is zero.
- R11: While reset is held, and after reset until the first start pulse, mem_req, rf_we and done are 0, and err, dirty, len_out and first_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load; accepted only when idle |
| cfg_dst | input | 5 | Destination base register |
| cfg_eew | input | 2 | Element width code (0..3 = 1,2,4,8 bytes) |
| cfg_grp | input | 4 | Registers per field group (1,2,4,8) |
| cfg_nf | input | 4 | Fields per element (1..8) |
| cfg_masked | input | 1 | Apply the mask vector |
| cfg_trunc | input | 1 | Truncate-on-fault mode |
| cfg_base | input | ADDR_W | Base address |
| cfg_len | input | IDX_W | Active length |
| cfg_first | input | IDX_W | Resume index |
| mask_bits | input | VLENB·8 | Mask vector, bit i for element i |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | ADDR_W | Read address |
| mem_eew | output | 2 | Read width code |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 64 | Read data, little-endian |
| mem_rsp_err | input | 1 | Read faulted |
| rf_we | output | 1 | Register-file write strobe |
| rf_reg | output | 5 | Register number |
| rf_off | output | log2(VLENB) | Byte offset inside the register |
| rf_eew | output | 2 | Write width code |
| rf_wdata | output | 64 | Write data, low bytes used |
| done | output | 1 | Completion pulse |
| err | output | 1 | Access fault reported |
| len_out | output | IDX_W | Resulting length |
| first_out | output | IDX_W | Resulting resume index |
| dirty | output | 1 | Register state was modified |

## Verification
The assertions assume that the memory side answers each request exactly once, never answers without a request outstanding, and never answers in the cycle the request is raised. They also assume that the latched shape is legal: every field group fits inside the 32 registers and the length fits the group. The stimulus holds to these assumptions through a responder that answers only a request it has already seen, after a latency that rotates between one and three cycles. All load shapes in the stimulus are chosen so that dst + nf·grp ≤ 32 and len ≤ grp·VLENB/eb.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;

    localparam int FLD_MAX = 8;
    localparam int FLD_W   = 3;
    localparam int WORD_W  = 64;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_REQ,
        S_WAIT,
        S_COMMIT
    } seq_state_e;

    typedef enum logic [1:0] {
        FIN_CLEAN,
        FIN_TRUNC,
        FIN_TRAP_MOVE,
        FIN_TRAP_KEEP
    } finish_e;

    typedef struct packed {
        logic [4:0] dst;
        logic [1:0] eew;
        logic [3:0] grp;
        logic [3:0] nf;
        logic       masked;
        logic       trunc;
    } shape_t;

    // Bytes of one whole segment in memory.
    function automatic logic [6:0] seg_bytes(input logic [3:0] nf, input logic [1:0] eew);
        return 7'({3'b000, nf} << eew);
    endfunction

    // Keeps the low element bytes of a returned word.
    function automatic logic [WORD_W-1:0] width_mask(input logic [1:0] eew);
        logic [WORD_W-1:0] m;
        for (int k = 0; k < WORD_W / 8; k++) begin
            m[k*8 +: 8] = (k < (1 << eew)) ? 8'hFF : 8'h00;
        end
        return m;
    endfunction

    // Outcome of a faulting read.
    function automatic finish_e fault_outcome(input logic trunc, input logic idx_nonzero,
                                              input logic past_first);
        if (trunc && idx_nonzero) begin
            return FIN_TRUNC;
        end else if (past_first) begin
            return FIN_TRAP_MOVE;
        end
        return FIN_TRAP_KEEP;
    endfunction

endpackage

// File: rtl/seg_load_addr.sv
module seg_load_addr
    import seg_load_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [FLD_W-1:0]  fld,
    input  logic [3:0]        nf,
    input  logic [1:0]        eew,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] seg_off;
    logic [ADDR_W-1:0] fld_off;

    assign seg_off = ADDR_W'(idx) * ADDR_W'(seg_bytes(nf, eew));
    assign fld_off = ADDR_W'(fld) << eew;
    assign addr    = base + seg_off + fld_off;
endmodule

// File: rtl/seg_load_place.sv
module seg_load_place
    import seg_load_pkg::*;
#(
    parameter int VLENB = 16,
    parameter int IDX_W = 8
) (
    input  logic [4:0]               dst,
    input  logic [3:0]               grp,
    input  logic [FLD_W-1:0]         fld,
    input  logic [1:0]               eew,
    input  logic [IDX_W-1:0]         idx,
    output logic [4:0]               rnum,
    output logic [$clog2(VLENB)-1:0] boff
);
    localparam int LOG_VB = $clog2(VLENB);
    localparam int OFF_W  = LOG_VB;

    logic [3:0]       sh;
    logic [IDX_W-1:0] reg_in_grp;
    logic [IDX_W-1:0] slot;
    logic [6:0]       grp_base;

    // Elements per register is 2^sh.
    assign sh         = 4'(LOG_VB) - {2'b00, eew};
    assign reg_in_grp = idx >> sh;
    assign slot       = idx & ((IDX_W'(1) << sh) - IDX_W'(1));
    assign grp_base   = 7'({4'b0000, fld} * {3'b000, grp});
    assign rnum       = dst + 5'(grp_base) + 5'(reg_in_grp);
    assign boff       = OFF_W'(slot << eew);
endmodule

// File: rtl/seg_load_fbuf.sv
module seg_load_fbuf
    import seg_load_pkg::*;
#(
    parameter int DEPTH = FLD_MAX,
    parameter int W     = WORD_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_data
);
    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0][W-1:0] view;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_en && wr_idx == IW'(g)) begin
                    q <= wr_data;
                end
            end
            assign view[g] = q;
        end
    endgenerate

    assign rd_data = view[rd_idx];
endmodule

// File: rtl/seg_load_seq.sv
module seg_load_seq
    import seg_load_pkg::*;
#(
    parameter int VLENB  = 16,
    parameter int ADDR_W = 32,
    localparam int VLEN     = VLENB * 8,
    localparam int LOG_VLEN = $clog2(VLEN),
    localparam int IDX_W    = LOG_VLEN + 1,
    localparam int OFF_W    = $clog2(VLENB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [4:0]        cfg_dst,
    input  logic [1:0]        cfg_eew,
    input  logic [3:0]        cfg_grp,
    input  logic [3:0]        cfg_nf,
    input  logic              cfg_masked,
    input  logic              cfg_trunc,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [IDX_W-1:0]  cfg_len,
    input  logic [IDX_W-1:0]  cfg_first,
    input  logic [VLEN-1:0]   mask_bits,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_eew,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              rf_we,
    output logic [4:0]        rf_reg,
    output logic [OFF_W-1:0]  rf_off,
    output logic [1:0]        rf_eew,
    output logic [63:0]       rf_wdata,
    output logic              done,
    output logic              err,
    output logic [IDX_W-1:0]  len_out,
    output logic [IDX_W-1:0]  first_out,
    output logic              dirty
);
    seq_state_e        state_q;
    shape_t            shape_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  len_q;
    logic [IDX_W-1:0]  first_q;
    logic [IDX_W-1:0]  idx_q;
    logic [FLD_W-1:0]  fld_q;
    logic [VLEN-1:0]   mask_q;

    logic              done_q;
    logic              err_q;
    logic              dirty_q;
    logic [IDX_W-1:0]  len_out_q;
    logic [IDX_W-1:0]  first_out_q;

    logic              last_fld;
    logic              elem_live;
    logic              at_end;
    logic              rsp_take;
    logic              finish_now;
    finish_e           fin_kind;
    logic [63:0]       buf_rd;

    assign last_fld  = ({1'b0, fld_q} == (shape_q.nf - 4'd1));
    assign elem_live = !shape_q.masked || mask_q[idx_q[LOG_VLEN-1:0]];
    assign at_end    = (idx_q >= len_q);
    assign rsp_take  = (state_q == S_WAIT) && mem_rsp_valid;

    always_comb begin
        finish_now = 1'b0;
        fin_kind   = FIN_CLEAN;
        if (state_q == S_SCAN && at_end) begin
            finish_now = 1'b1;
        end else if (rsp_take && mem_rsp_err) begin
            finish_now = 1'b1;
            fin_kind   = fault_outcome(shape_q.trunc, idx_q != '0, idx_q > first_q);
        end
    end

    // Element walk and field sequencing.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            shape_q <= '0;
            base_q  <= '0;
            len_q   <= '0;
            first_q <= '0;
            idx_q   <= '0;
            fld_q   <= '0;
            mask_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        shape_q <= '{dst: cfg_dst, eew: cfg_eew, grp: cfg_grp, nf: cfg_nf,
                                     masked: cfg_masked, trunc: cfg_trunc};
                        base_q  <= cfg_base;
                        len_q   <= cfg_len;
                        first_q <= cfg_first;
                        idx_q   <= cfg_first;
                        mask_q  <= mask_bits;
                        state_q <= S_SCAN;
                    end
                end
                S_SCAN: begin
                    if (at_end) begin
                        state_q <= S_IDLE;
                    end else if (!elem_live) begin
                        idx_q <= idx_q + IDX_W'(1);
                    end else begin
                        fld_q   <= '0;
                        state_q <= S_REQ;
                    end
                end
                S_REQ: begin
                    state_q <= S_WAIT;
                end
                S_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            state_q <= S_IDLE;
                        end else if (last_fld) begin
                            fld_q   <= '0;
                            state_q <= S_COMMIT;
                        end else begin
                            fld_q   <= fld_q + FLD_W'(1);
                            state_q <= S_REQ;
                        end
                    end
                end
                S_COMMIT: begin
                    if (last_fld) begin
                        idx_q   <= idx_q + IDX_W'(1);
                        state_q <= S_SCAN;
                    end else begin
                        fld_q <= fld_q + FLD_W'(1);
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Outcome registers, held until the next finish.
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            dirty_q     <= 1'b0;
            len_out_q   <= '0;
            first_out_q <= '0;
        end else begin
            done_q <= finish_now;
            if (finish_now) begin
                case (fin_kind)
                    FIN_CLEAN: begin
                        err_q       <= 1'b0;
                        dirty_q     <= 1'b1;
                        len_out_q   <= len_q;
                        first_out_q <= '0;
                    end
                    FIN_TRUNC: begin
                        err_q       <= 1'b0;
                        dirty_q     <= 1'b1;
                        len_out_q   <= idx_q;
                        first_out_q <= '0;
                    end
                    FIN_TRAP_MOVE: begin
                        err_q       <= 1'b1;
                        dirty_q     <= 1'b1;
                        len_out_q   <= len_q;
                        first_out_q <= idx_q;
                    end
                    default: begin
                        err_q       <= 1'b1;
                        dirty_q     <= 1'b0;
                        len_out_q   <= len_q;
                        first_out_q <= first_q;
                    end
                endcase
            end
        end
    end

    seg_load_addr #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_addr (
        .base(base_q),
        .idx (idx_q),
        .fld (fld_q),
        .nf  (shape_q.nf),
        .eew (shape_q.eew),
        .addr(mem_addr)
    );

    seg_load_place #(
        .VLENB(VLENB),
        .IDX_W(IDX_W)
    ) u_place (
        .dst (shape_q.dst),
        .grp (shape_q.grp),
        .fld (fld_q),
        .eew (shape_q.eew),
        .idx (idx_q),
        .rnum(rf_reg),
        .boff(rf_off)
    );

    seg_load_fbuf #(
        .DEPTH(FLD_MAX),
        .W    (WORD_W)
    ) u_fbuf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (rsp_take && !mem_rsp_err),
        .wr_idx (fld_q),
        .wr_data(mem_rsp_data & width_mask(shape_q.eew)),
        .rd_idx (fld_q),
        .rd_data(buf_rd)
    );

    assign mem_req   = (state_q == S_REQ);
    assign mem_eew   = shape_q.eew;
    assign rf_we     = (state_q == S_COMMIT);
    assign rf_eew    = shape_q.eew;
    assign rf_wdata  = buf_rd;
    assign done      = done_q;
    assign err       = err_q;
    assign dirty     = dirty_q;
    assign len_out   = len_out_q;
    assign first_out = first_out_q;
endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk #(
    parameter int VLENB = 16,
    localparam int IDX_W = $clog2(VLENB * 8) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_req,
    input logic             mem_rsp_valid,
    input logic             rf_we,
    input logic             done,
    input logic             err,
    input logic             dirty,
    input logic [IDX_W-1:0] len_out,
    input logic [IDX_W-1:0] first_out,
    input logic [IDX_W-1:0] len_lat,
    input logic [IDX_W-1:0] first_lat,
    input logic             trunc_lat
);
    logic outst;

    always_ff @(posedge clk) begin
        if (rst) begin
            outst <= 1'b0;
        end else if (mem_req) begin
            outst <= 1'b1;
        end else if (mem_rsp_valid) begin
            outst <= 1'b0;
        end
    end

    p_single_req_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !outst);

    p_req_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    p_hold_writes_r4: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> !outst);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_clean_finish_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (first_out == '0 && dirty));

    p_trap_len_r7: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (len_out == len_lat));

    p_trap_dirty_r7: assert property (@(posedge clk) disable iff (rst)
        (done && err && dirty) |-> (first_out > first_lat));

    // R6 and R8: a shortened length only in truncate mode, and never to zero
    p_trunc_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !err && len_out != len_lat) |-> (trunc_lat && len_out != '0));
endmodule

bind seg_load_seq seg_load_chk #(.VLENB(VLENB)) u_seg_load_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_req      (mem_req),
    .mem_rsp_valid(mem_rsp_valid),
    .rf_we        (rf_we),
    .done         (done),
    .err          (err),
    .dirty        (dirty),
    .len_out      (len_out),
    .first_out    (first_out),
    .len_lat      (len_q),
    .first_lat    (first_q),
    .trunc_lat    (shape_q.trunc)
);

// File: tb/seg_load_seq_bench.sv
module seg_load_seq_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int VLENB  = 16;
    localparam int ADDR_W = 32;
    localparam int VLEN   = VLENB * 8;
    localparam int IDX_W  = 8;
    localparam int OFF_W  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              start = 1'b0;
    logic [4:0]        cfg_dst = '0;
    logic [1:0]        cfg_eew = '0;
    logic [3:0]        cfg_grp = 4'd1;
    logic [3:0]        cfg_nf = 4'd1;
    logic              cfg_masked = 1'b0;
    logic              cfg_trunc = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [IDX_W-1:0]  cfg_len = '0;
    logic [IDX_W-1:0]  cfg_first = '0;
    logic [VLEN-1:0]   mask_v = '0;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [1:0]        mem_eew;
    logic              mem_rsp_valid;
    logic [63:0]       mem_rsp_data;
    logic              mem_rsp_err;
    logic              rf_we;
    logic [4:0]        rf_reg;
    logic [OFF_W-1:0]  rf_off;
    logic [1:0]        rf_eew;
    logic [63:0]       rf_wdata;
    logic              done;
    logic              err;
    logic [IDX_W-1:0]  len_out;
    logic [IDX_W-1:0]  first_out;
    logic              dirty;

    seg_load_seq #(.VLENB(VLENB), .ADDR_W(ADDR_W)) u_seg_load_seq (
        .clk(clk), .rst(rst), .start(start),
        .cfg_dst(cfg_dst), .cfg_eew(cfg_eew), .cfg_grp(cfg_grp), .cfg_nf(cfg_nf),
        .cfg_masked(cfg_masked), .cfg_trunc(cfg_trunc), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .cfg_first(cfg_first), .mask_bits(mask_v),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_eew(mem_eew),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .rf_we(rf_we), .rf_reg(rf_reg), .rf_off(rf_off), .rf_eew(rf_eew), .rf_wdata(rf_wdata),
        .done(done), .err(err), .len_out(len_out), .first_out(first_out), .dirty(dirty)
    );

    typedef struct packed {
        logic [4:0]       r;
        logic [OFF_W-1:0] off;
        logic [1:0]       w;
        logic [63:0]      d;
    } wr_t;

    wr_t         exp_wr[$];
    logic [31:0] exp_addr[$];
    int          checks = 0;
    int          errors = 0;
    logic        fault_en = 1'b0;
    logic [31:0] fault_addr = '0;
    int          lat_sel = 0;

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic check_eq(input string tag, input string what,
                            input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Memory responder: compares each request address with the scoreboard.
    initial begin
        bit          pend;
        int          cnt;
        logic [31:0] cap;
        pend = 0; cnt = 0; cap = '0;
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_err   = fault_en && (cap == fault_addr);
                    for (int k = 0; k < 8; k++) mem_rsp_data[k*8 +: 8] = mbyte(cap + 32'(k));
                    pend = 0;
                end else begin
                    cnt--;
                end
            end
            if (!rst && mem_req) begin
                check_eq("R9", "request while one outstanding", 64'(pend), 64'd0);
                if (exp_addr.size() == 0) begin
                    check_eq("R1", "unexpected request address", 64'(mem_addr), 64'hDEAD);
                end else begin
                    check_eq("R1", "request address", 64'(mem_addr), 64'(exp_addr.pop_front()));
                end
                cap  = mem_addr;
                pend = 1;
                cnt  = lat_sel % 3;
                lat_sel++;
            end
        end
    end

    // Write monitor: pops expected register writes.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rf_we) begin
                if (exp_wr.size() == 0) begin
                    check_eq("R4", "unexpected register write", 64'(rf_reg), 64'h3F);
                end else begin
                    wr_t e;
                    e = exp_wr.pop_front();
                    check_eq("R3", "write register", 64'(rf_reg), 64'(e.r));
                    check_eq("R3", "write offset", 64'(rf_off), 64'(e.off));
                    check_eq("R3", "write width", 64'(rf_eew), 64'(e.w));
                    check_eq("R10", "write data", rf_wdata, e.d);
                end
            end
        end
    end

    task automatic run_op(input string tag, input logic [4:0] dst, input logic [1:0] eew,
                          input logic [3:0] grp, input logic [3:0] nf, input bit masked,
                          input bit trunc, input logic [31:0] base, input int len,
                          input int first, input bit fen, input logic [31:0] faddr);
        int   eb;
        int   epr;
        int   fault_i;
        bit   e_err;
        bit   e_dirty;
        int   e_len;
        int   e_first;
        int   guard;
        string st;
        eb = 1 << eew;
        epr = VLENB / eb;
        fault_i = -1;
        fault_en = fen;
        fault_addr = faddr;
        for (int i = first; i < len && fault_i < 0; i++) begin
            if (masked && !mask_v[i]) continue;
            for (int f = 0; f < int'(nf); f++) begin
                logic [31:0] a;
                a = base + 32'(i * int'(nf) * eb) + 32'(f * eb);
                exp_addr.push_back(a);
                if (fen && a == faddr) begin
                    fault_i = i;
                    break;
                end
            end
            if (fault_i < 0) begin
                for (int f = 0; f < int'(nf); f++) begin
                    wr_t w;
                    logic [31:0] a;
                    a = base + 32'(i * int'(nf) * eb) + 32'(f * eb);
                    w.r = 5'(int'(dst) + f * int'(grp) + i / epr);
                    w.off = OFF_W'((i % epr) * eb);
                    w.w = eew;
                    w.d = '0;
                    for (int k = 0; k < eb; k++) w.d[k*8 +: 8] = mbyte(a + 32'(k));
                    exp_wr.push_back(w);
                end
            end
        end
        if (fault_i < 0) begin
            e_err = 0; e_dirty = 1; e_len = len; e_first = 0; st = "R5";
        end else if (trunc && fault_i > 0) begin
            e_err = 0; e_dirty = 1; e_len = fault_i; e_first = 0; st = "R6";
        end else if (fault_i > first) begin
            e_err = 1; e_dirty = 1; e_len = len; e_first = fault_i; st = "R7";
        end else begin
            e_err = 1; e_dirty = 0; e_len = len; e_first = first;
            st = (trunc && fault_i == 0) ? "R8" : "R7";
        end

        @(negedge clk);
        cfg_dst = dst; cfg_eew = eew; cfg_grp = grp; cfg_nf = nf;
        cfg_masked = masked; cfg_trunc = trunc; cfg_base = base;
        cfg_len = IDX_W'(len); cfg_first = IDX_W'(first);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check_eq(st, {tag, " done seen"}, 64'(done), 64'd1);
        check_eq(st, {tag, " err"}, 64'(err), 64'(e_err));
        check_eq(st, {tag, " dirty"}, 64'(dirty), 64'(e_dirty));
        check_eq(st, {tag, " length"}, 64'(len_out), 64'(e_len));
        check_eq(st, {tag, " resume index"}, 64'(first_out), 64'(e_first));
        @(negedge clk);
        check_eq("R5", {tag, " done single pulse"}, 64'(done), 64'd0);
        check_eq(masked ? "R2" : "R1", {tag, " requests left"}, 64'(exp_addr.size()), 64'd0);
        check_eq("R4", {tag, " writes left"}, 64'(exp_wr.size()), 64'd0);
        exp_addr.delete();
        exp_wr.delete();
        fault_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check_eq("R11", "mem_req in reset", 64'(mem_req), 64'd0);
        check_eq("R11", "rf_we in reset", 64'(rf_we), 64'd0);
        check_eq("R11", "done in reset", 64'(done), 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R11", "idle after reset", 64'({mem_req, rf_we, done, err, dirty}), 64'd0);
        check_eq("R11", "outputs after reset", 64'({len_out, first_out}), 64'd0);

        // R1/R3: plain load, mask vector all zero but masking off (R2)
        mask_v = '0;
        run_op("plain", 5'd4, 2'd2, 4'd1, 4'd1, 0, 0, 32'h0000_1000, 4, 0, 0, 0);
        // R1/R3: three fields, group of two, crossing a register
        run_op("seg3", 5'd8, 2'd1, 4'd2, 4'd3, 0, 0, 32'h0000_2200, 12, 0, 0, 0);
        // R2: masked with a resume index
        mask_v = 128'h5AC3;
        run_op("masked", 5'd2, 2'd0, 4'd1, 4'd2, 1, 0, 32'h0000_0310, 16, 3, 0, 0);
        // R3/R10: eight-byte elements in a group of four
        run_op("wide", 5'd12, 2'd3, 4'd4, 4'd1, 0, 0, 32'h0000_5008, 6, 0, 0, 0);
        // R6: truncate at element 2, fault on field 1 (R4: element 2 unwritten)
        run_op("trunc", 5'd4, 2'd2, 4'd1, 4'd2, 0, 1, 32'h0000_2000, 5, 0, 1, 32'h0000_2014);
        // R8: truncate mode, fault at element 0
        run_op("elem0", 5'd6, 2'd2, 4'd1, 4'd1, 0, 1, 32'h0000_3000, 4, 0, 1, 32'h0000_3000);
        // R7: trap past the resume index
        run_op("trapmove", 5'd10, 2'd1, 4'd1, 4'd1, 0, 0, 32'h0000_4000, 6, 1, 1, 32'h0000_4006);
        // R7: trap at the resume index
        run_op("trapkeep", 5'd10, 2'd1, 4'd1, 4'd1, 0, 0, 32'h0000_4000, 6, 2, 1, 32'h0000_4004);
        // R5: resume index at length, no reads
        run_op("empty", 5'd1, 2'd0, 4'd1, 4'd1, 0, 0, 32'h0000_6000, 5, 5, 0, 0);
        // R1: address wraps around the top
        run_op("wrap", 5'd20, 2'd2, 4'd1, 4'd2, 0, 0, 32'hFFFF_FFF8, 3, 0, 0, 0);
        // R2: a faulting address on a dead element is never read
        mask_v = 128'hFB;
        run_op("deadfault", 5'd16, 2'd2, 4'd1, 4'd1, 1, 0, 32'h0000_7000, 6, 0, 1, 32'h0000_7008);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule